// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an operand held in an unpacked floating-point form into a signed two's-complement integer of `INT_W` bits (32 or 64). The operand arrives as a sign bit, a class code, a signed unbiased exponent and a normalized mantissa. The mantissa carries an explicit leading one in its top bit. The operand's value is `mant * 2^(exp - (MANT_W-1))`.

The conversion always truncates toward zero, whatever rounding mode the rest of the datapath uses. Any dropped fraction bit raises an inexact flag. A result that does not fit, an infinity or a NaN raises an invalid flag instead. In those cases the output saturates according to the sign.

The block has one register stage. An operand presented with `in_valid_i` high produces its result on the following cycle, with `out_valid_o` high. While no operand is presented, the outputs keep their last values.

Top module: `fp2int_cvt`

## Requirements
- R1: Class code 0 (zero) gives result 0 with both flags clear, whatever the sign, exponent and mantissa.
- R2: For class code 1 (normal) with an in-range value, the result is the integer part of the magnitude, negated when the sign is 1. It is never incremented by rounding.
- R3: For an in-range normal, inexact is 1 exactly when at least one mantissa bit below the binary point is 1; invalid is 0.
- R4: A normal with a negative exponent (magnitude below 1.0) gives result 0 with inexact set.
- R5: A normal with exponent at or above `INT_W` overflows: invalid is 1, inexact is 0 and the result saturates as in R8.
- R6: A truncated magnitude of exactly 2^(INT_W-1) is accepted for sign 1, giving the most negative integer. For sign 0 it overflows. Any larger truncated magnitude overflows for both signs.
- R7: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 all give invalid 1, inexact 0 and a saturated result.
- R8: The saturated result is 2^(INT_W-1)-1 (top bit 0, others 1) for sign 0, and -2^(INT_W-1) (top bit 1, others 0) for sign 1.
- R9: `out_valid_o` equals `in_valid_i` of the previous cycle. While `in_valid_i` is low, the result and flags keep their values.
- R10: While `rst_ni` is low, `out_valid_o`, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand present this cycle |
| sign_i | input | 1 | Operand sign, 1 is negative |
| cls_i | input | 3 | Operand class code (see R1, R2, R7) |
| exp_i | input | EXP_W | Unbiased exponent, two's complement |
| mant_i | input | MANT_W | Mantissa, leading one in bit MANT_W-1 |
| out_valid_o | output | 1 | Result present |
| res_o | output | INT_W | Signed integer result |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Overflow or non-numeric operand |

## Verification
There is only one register stage, so any fault in the alignment shift or the range logic appears at the ports on the cycle right after the operand. A shift amount that is off by one shows up as a result doubled or halved. A sticky mask that is off by one shows up as a wrong inexact flag on values whose only set fraction bit lies next to the binary point. A fault at the overflow boundary shows up only at exponent `INT_W-1` with a magnitude of exactly 2^(INT_W-1), so those operands are driven with both signs and with and without fraction bits.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NORM = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fclass_e;
endpackage

// File: rtl/fcvt_align.sv
module fcvt_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = INT_W + 8,
  parameter int EXP_W  = 16
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  output logic        [INT_W-1:0]  mag_o,
  output logic                     sticky_o,
  output logic                     big_o
);
  localparam int SH_W = $clog2(MANT_W + 1);

  logic signed [EXP_W+1:0] sh_full;
  logic [SH_W-1:0]         sh;
  logic [MANT_W-1:0]       shifted;
  logic [MANT_W-1:0]       lo_mask;

  // right shift that puts the binary point below bit 0
  assign sh_full = $signed((EXP_W+2)'(MANT_W - 1)) - (EXP_W+2)'(exp_i);
  assign big_o   = exp_i >= $signed(EXP_W'(INT_W));

  always_comb begin
    if (sh_full <= 0)                              sh = '0;
    else if (sh_full >= $signed((EXP_W+2)'(MANT_W))) sh = SH_W'(MANT_W);
    else                                           sh = sh_full[SH_W-1:0];
  end

  assign shifted  = mant_i >> sh;
  assign lo_mask  = ~({MANT_W{1'b1}} << sh);
  assign sticky_o = |(mant_i & lo_mask);
  assign mag_o    = shifted[INT_W-1:0];
endmodule

// File: rtl/fcvt_pack.sv
module fcvt_pack
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  logic [2:0]       cls_i,
  input  logic             big_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             sticky_i,
  output logic [INT_W-1:0] res_o,
  output logic             inexact_o,
  output logic             invalid_o
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic is_zero, is_norm, range_ovf, ovf;

  assign is_zero   = cls_i == FC_ZERO;
  assign is_norm   = cls_i == FC_NORM;
  assign range_ovf = (mag_i > HALF) || ((mag_i == HALF) && !sign_i);
  assign ovf       = !is_zero && (!is_norm || big_i || range_ovf);

  always_comb begin
    if (is_zero) begin
      res_o     = '0;
      inexact_o = 1'b0;
      invalid_o = 1'b0;
    end else if (ovf) begin
      res_o     = sign_i ? HALF : ~HALF;
      inexact_o = 1'b0;
      invalid_o = 1'b1;
    end else begin
      res_o     = sign_i ? (~mag_i + 1'b1) : mag_i;
      inexact_o = sticky_i;
      invalid_o = 1'b0;
    end
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import fcvt_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = INT_W + 8,
  parameter int EXP_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic                     sign_i,
  input  logic [2:0]               cls_i,
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0]        mant_i,
  output logic                     out_valid_o,
  output logic [INT_W-1:0]         res_o,
  output logic                     inexact_o,
  output logic                     invalid_o
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  if (INT_W != 32 && INT_W != 64) begin : g_bad_width
    $error("fp2int_cvt: INT_W must be 32 or 64");
  end
  if (MANT_W < INT_W + 2) begin : g_bad_mant
    $error("fp2int_cvt: MANT_W must be at least INT_W+2");
  end

  logic [INT_W-1:0] mag;
  logic             sticky, big;
  logic [INT_W-1:0] res_d;
  logic             inexact_d, invalid_d;

  fcvt_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i   (exp_i),
    .mant_i  (mant_i),
    .mag_o   (mag),
    .sticky_o(sticky),
    .big_o   (big)
  );

  fcvt_pack #(.INT_W(INT_W)) u_pack (
    .sign_i   (sign_i),
    .cls_i    (cls_i),
    .big_i    (big),
    .mag_i    (mag),
    .sticky_i (sticky),
    .res_o    (res_d),
    .inexact_o(inexact_d),
    .invalid_o(invalid_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
      inexact_o   <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_o     <= res_d;
        inexact_o <= inexact_d;
        invalid_o <= invalid_d;
      end
    end
  end

  p_zero_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && cls_i == FC_ZERO) |=> (res_o == '0 && !inexact_o && !invalid_o));

  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> !inexact_o);

  p_nonnum_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && cls_i >= 3'd2) |=> invalid_o);

  p_sat_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (res_o == HALF || res_o == ~HALF));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (out_valid_o == $past(in_valid_i)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(in_valid_i)) |->
      ($stable(res_o) && $stable(inexact_o) && $stable(invalid_o)));
endmodule

// File: tb/fp2int_cvt_tb.sv
`timescale 1ns/1ps
module fp2int_cvt_tb;
  localparam int INT_W  = 32;
  localparam int MANT_W = INT_W + 8;
  localparam int EXP_W  = 16;
  localparam logic [MANT_W-1:0] LEAD = {1'b1, {(MANT_W-1){1'b0}}};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic sign_i = 1'b0;
  logic [2:0] cls_i = 3'd0;
  logic signed [EXP_W-1:0] exp_i = '0;
  logic [MANT_W-1:0] mant_i = '0;
  logic out_valid_o;
  logic [INT_W-1:0] res_o;
  logic inexact_o, invalid_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  fp2int_cvt #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .sign_i(sign_i),
    .cls_i(cls_i), .exp_i(exp_i), .mant_i(mant_i), .out_valid_o(out_valid_o),
    .res_o(res_o), .inexact_o(inexact_o), .invalid_o(invalid_o)
  );

  function automatic logic [INT_W-1:0] sat(bit s);
    return s ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
  endfunction

  // {result, inexact, invalid}
  function automatic logic [INT_W+1:0] ref_cvt(bit s, bit [2:0] c, int e, logic [MANT_W-1:0] m);
    longint unsigned mag = 0;
    bit st = 0;
    int sh;
    longint unsigned lim = 64'd1 << (INT_W - 1);
    if (c == 3'd0) return '0;
    if (c != 3'd1 || e >= INT_W) return {sat(s), 2'b01};
    sh = MANT_W - 1 - e;
    for (int i = 0; i < MANT_W; i++)
      if (m[i]) begin
        if (i < sh) st = 1;
        else mag += 64'd1 << (i - sh);
      end
    if (mag > lim || (mag == lim && !s)) return {sat(s), 2'b01};
    return {s ? INT_W'(64'd0 - mag) : INT_W'(mag), st, 1'b0};
  endfunction

  task automatic check(string req, logic [INT_W+1:0] expv);
    total++;
    if (out_valid_o !== 1'b1 || {res_o, inexact_o, invalid_o} !== expv) begin
      bad++;
      $display("FAIL %s: actual v=%b res=%h nx=%b nv=%b expected v=1 res=%h nx=%b nv=%b",
               req, out_valid_o, res_o, inexact_o, invalid_o,
               expv[INT_W+1:2], expv[1], expv[0]);
    end
  endtask

  logic [INT_W+1:0] last_exp;

  task automatic apply(string req, bit s, bit [2:0] c, int e, logic [MANT_W-1:0] m);
    sign_i = s; cls_i = c; exp_i = EXP_W'(e); mant_i = m; in_valid_i = 1'b1;
    last_exp = ref_cvt(s, c, e, m);
    @(negedge clk_i);
    check(req, last_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL R9: watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    total++;
    if (out_valid_o !== 1'b0 || res_o !== '0 || inexact_o !== 1'b0 || invalid_o !== 1'b0) begin
      bad++;
      $display("FAIL R10: actual v=%b res=%h nx=%b nv=%b expected all zero",
               out_valid_o, res_o, inexact_o, invalid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: zero ignores the other fields
    apply("R1", 1'b1, 3'd0, 20, '1);
    apply("R1", 1'b0, 3'd0, -5, 40'h12345);
    // R2 / R3: exact and truncated in-range values
    apply("R2", 1'b0, 3'd1, 0, LEAD);
    apply("R2", 1'b1, 3'd1, 5, LEAD | (LEAD >> 3));
    apply("R3", 1'b1, 3'd1, 1, LEAD | (LEAD >> 2));
    apply("R3", 1'b0, 3'd1, 30, '1);
    apply("R3", 1'b0, 3'd1, 3, LEAD | 40'd1);
    // R4: just below 1.0 and tiny values
    apply("R4", 1'b0, 3'd1, -1, '1);
    apply("R4", 1'b1, 3'd1, -30, LEAD);
    // R5: exponent boundary
    apply("R5", 1'b0, 3'd1, INT_W, LEAD);
    apply("R5", 1'b1, 3'd1, INT_W, LEAD);
    apply("R5", 1'b1, 3'd1, 200, '1);
    apply("R2", 1'b0, 3'd1, INT_W - 2, '1);
    // R6: exactly 2^(N-1)
    apply("R6", 1'b1, 3'd1, INT_W - 1, LEAD);
    apply("R6", 1'b0, 3'd1, INT_W - 1, LEAD);
    apply("R6", 1'b1, 3'd1, INT_W - 1, LEAD | 40'h80);
    apply("R6", 1'b1, 3'd1, INT_W - 1, LEAD | 40'h100);
    apply("R6", 1'b0, 3'd1, INT_W - 1, '1);
    // R7 / R8: every non-numeric code, both signs
    for (int c = 2; c < 8; c++) begin
      apply("R7", 1'b0, 3'(c), 3, LEAD);
      apply("R8", 1'b1, 3'(c), -2, '1);
    end

    // R9: hold while idle
    in_valid_i = 1'b0; sign_i = 1'b1; cls_i = 3'd2; exp_i = 16'sd7;
    @(negedge clk_i);
    total++;
    if (out_valid_o !== 1'b0 || {res_o, inexact_o, invalid_o} !== last_exp) begin
      bad++;
      $display("FAIL R9: actual v=%b res=%h nx=%b nv=%b expected v=0 res=%h nx=%b nv=%b",
               out_valid_o, res_o, inexact_o, invalid_o,
               last_exp[INT_W+1:2], last_exp[1], last_exp[0]);
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int e = int'($urandom_range(0, 48)) - 6;
      int cr = int'($urandom_range(0, 15));
      bit [2:0] c = (cr < 12) ? 3'd1 : 3'(cr - 10);
      logic [MANT_W-1:0] m = LEAD | MANT_W'({$urandom, $urandom});
      if ($urandom_range(0, 3) == 0) m = LEAD;
      apply("R2", 1'(($urandom)), c, e, m);
    end

    in_valid_i = 1'b0;
    @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule